// File: doc/BRIEF.md
# Ethernet PHY Control and Status Register Bank

This block is the software-visible register bank of a multi-rate Ethernet PCS. A host reaches it through a single-cycle memory-mapped slave port with no wait states. The port has a word address, read and write strobes and 32-bit write and read data. The bank holds the operating controls and drives them straight out as ports: the mode select, auto-negotiation enable, manual speed code, link timer setting and serial loopback enable. It also issues a one-cycle negotiation restart pulse when software asks for one.

In the other direction, the bank samples the link, negotiation-complete and link-partner ability signals from the PCS and presents them as read-only words. The link bit is latched low, so a link drop is visible to software at least once even if the link recovers before the next poll. Read data is registered. Reserved bits and unmapped addresses read as zero and ignore writes.

Top module: `eth_phy_csr`

## Requirements
- R1: After reset the control word (0x400) reads 0x0000_0002, the link timer word (0x412) reads 0x0007_C000, and the status (0x401) and loopback (0x461) words read 0. The outputs are `usx_mode_o`=0, `an_en_o`=1, `man_speed_o`=0, `link_timer_o`=0x1F, `serial_lpbk_o`=0 and `an_restart_o`=0.
- R2: In the control word at 0x400, bit 0 (mode: 0 = 10GBASE-R, 1 = USXGMII), bit 1 (auto-negotiation enable) and bits [4:2] (manual speed: 000=10M, 001=100M, 010=1G, 011=10G, 100=2.5G, 101=5G, 110/111 reserved) are read/write. They drive `usx_mode_o`, `an_en_o` and `man_speed_o` from the clock after the write.
- R3: Writing 1 to bit 9 of 0x400 sets a restart bit that drives `an_restart_o` high for exactly one cycle, starting the cycle after the write; the bit then clears itself. Writing 0 to bit 9 produces no pulse.
- R4: Bit 5 of the status word at 0x401 returns the value of `an_done_i` in the cycle the read is issued.
- R5: Bit 2 of 0x401 is a latched-low link flag. It is cleared in any cycle where `link_i` is 0. It is reloaded from `link_i` only by a read of 0x401, and that read returns the value held before the reload.
- R6: The partner word at 0x405 is read-only. It returns `partner_ability_i` bits 7 (EEE clock stop), 8 (EEE), [11:9] (speed code as in R2), 12 (duplex, 1 = full), 14 (acknowledge) and 15 (link) at the same positions, with every other bit 0.
- R7: In the link timer word at 0x412, bits [19:14] are read/write and drive `link_timer_o`. Bits [13:0] always read 0.
- R8: Bit 0 of the word at 0x461 is read/write and drives `serial_lpbk_o`.
- R9: Reserved bits and unmapped addresses read as 0, and writes to them change no register or output.
- R10: `rdata_o` is loaded the clock after `rd_i` is sampled high and holds its value while `rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 11 | Word address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| link_i | input | 1 | Live link indication from the PCS |
| an_done_i | input | 1 | Auto-negotiation complete from the PCS |
| partner_ability_i | input | 16 | Link-partner ability word from the negotiation engine |
| usx_mode_o | output | 1 | Mode select, 1 = USXGMII |
| an_en_o | output | 1 | Auto-negotiation enable |
| man_speed_o | output | 3 | Manual speed code |
| an_restart_o | output | 1 | One-cycle negotiation restart pulse |
| link_timer_o | output | 6 | Link timer setting |
| serial_lpbk_o | output | 1 | PMA serial loopback enable |

## Verification
The bench first reads the status word twice with the link up. The first read must still show 0 from reset and the second must show 1. A latch that rearmed on its own, or tracked the live link, would return 1 on the first read. It then drops the link for a single cycle and restores it before polling. A design without the latch would miss that drop entirely.

The restart write is followed by a cycle-by-cycle look at `an_restart_o` and a pulse count. A bit that failed to self-clear would show a level instead of a pulse. A write of 0 must produce no pulse at all. All-ones writes to the control, timer and unmapped words expose writable reserved bits and aliasing address decodes. The link timer check catches a field placed at the wrong offset.

// File: rtl/eth_phy_csr_pkg.sv
package eth_phy_csr_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned SPEED_W    = 3;
  localparam int unsigned TIMER_W    = 6;
  localparam int unsigned TIMER_LSB  = 14;
  localparam int unsigned ABIL_W     = 16;

  localparam int unsigned A_CTRL     = 'h400;
  localparam int unsigned A_STATUS   = 'h401;
  localparam int unsigned A_PARTNER  = 'h405;
  localparam int unsigned A_TIMER    = 'h412;
  localparam int unsigned A_LPBK     = 'h461;

  localparam int unsigned CTRL_RESTART_BIT = 9;
  localparam int unsigned STAT_LINK_BIT    = 2;
  localparam int unsigned STAT_DONE_BIT    = 5;

  // partner bits passed through: 7,8,11:9,12,14,15
  localparam logic [ABIL_W-1:0] PARTNER_MASK = 16'hDF80;
  localparam logic [TIMER_W-1:0] TIMER_RST   = 6'h1F;

  typedef struct packed {
    logic [SPEED_W-1:0] speed;
    logic               an_en;
    logic               usx_mode;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{speed: '0, an_en: 1'b1, usx_mode: 1'b0};
endpackage

// File: rtl/eth_phy_csr_ctrl.sv
module eth_phy_csr_ctrl
  import eth_phy_csr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  ctrl_t wfield_i,
  input  logic  wrestart_i,
  output ctrl_t ctrl_o,
  output logic  restart_o
);
  ctrl_t ctrl_q;
  logic  restart_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= CTRL_RST;
      restart_q <= 1'b0;
    end else begin
      if (we_i) ctrl_q <= wfield_i;
      // self-clearing: set by write, dropped on the following clock
      restart_q <= we_i & wrestart_i;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/eth_phy_csr_link_latch.sv
module eth_phy_csr_link_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_i,
  input  logic rearm_i,
  output logic latched_o
);
  logic lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= 1'b0;
    else if (rearm_i) lat_q <= link_i;
    else if (!link_i) lat_q <= 1'b0;
  end

  assign latched_o = lat_q;
endmodule

// File: rtl/eth_phy_csr_field.sv
module eth_phy_csr_field #(
  parameter int unsigned     W   = 1,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/eth_phy_csr.sv
module eth_phy_csr
  import eth_phy_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                link_i,
  input  logic                an_done_i,
  input  logic [ABIL_W-1:0]   partner_ability_i,
  output logic                usx_mode_o,
  output logic                an_en_o,
  output logic [SPEED_W-1:0]  man_speed_o,
  output logic                an_restart_o,
  output logic [TIMER_W-1:0]  link_timer_o,
  output logic                serial_lpbk_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL    = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_STATUS  = ADDR_W'(A_STATUS);
  localparam logic [ADDR_W-1:0] AD_PARTNER = ADDR_W'(A_PARTNER);
  localparam logic [ADDR_W-1:0] AD_TIMER   = ADDR_W'(A_TIMER);
  localparam logic [ADDR_W-1:0] AD_LPBK    = ADDR_W'(A_LPBK);
  localparam int unsigned TIMER_MSB = TIMER_LSB + TIMER_W - 1;

  logic sel_ctrl, sel_status, sel_partner, sel_timer, sel_lpbk;
  assign sel_ctrl    = (addr_i == AD_CTRL);
  assign sel_status  = (addr_i == AD_STATUS);
  assign sel_partner = (addr_i == AD_PARTNER);
  assign sel_timer   = (addr_i == AD_TIMER);
  assign sel_lpbk    = (addr_i == AD_LPBK);

  ctrl_t ctrl_w, ctrl_q;
  logic  restart_q, link_lat;
  assign ctrl_w = '{speed: wdata_i[4:2], an_en: wdata_i[1], usx_mode: wdata_i[0]};

  eth_phy_csr_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_i & sel_ctrl),
    .wfield_i   (ctrl_w),
    .wrestart_i (wdata_i[CTRL_RESTART_BIT]),
    .ctrl_o     (ctrl_q),
    .restart_o  (restart_q)
  );

  eth_phy_csr_link_latch u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_i    (link_i),
    .rearm_i   (rd_i & sel_status),
    .latched_o (link_lat)
  );

  eth_phy_csr_field #(.W(TIMER_W), .RST(TIMER_RST)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & sel_timer),
    .wdata_i (wdata_i[TIMER_MSB:TIMER_LSB]),
    .q_o     (link_timer_o)
  );

  eth_phy_csr_field #(.W(1), .RST(1'b0)) u_lpbk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i & sel_lpbk),
    .wdata_i (wdata_i[0]),
    .q_o     (serial_lpbk_o)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ctrl) begin
      rd_mux[4:0]              = ctrl_q;
      rd_mux[CTRL_RESTART_BIT] = restart_q;
    end else if (sel_status) begin
      rd_mux[STAT_LINK_BIT] = link_lat;
      rd_mux[STAT_DONE_BIT] = an_done_i;
    end else if (sel_partner) begin
      rd_mux[ABIL_W-1:0] = partner_ability_i & PARTNER_MASK;
    end else if (sel_timer) begin
      rd_mux[TIMER_MSB:TIMER_LSB] = link_timer_o;
    end else if (sel_lpbk) begin
      rd_mux[0] = serial_lpbk_o;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  assign usx_mode_o   = ctrl_q.usx_mode;
  assign an_en_o      = ctrl_q.an_en;
  assign man_speed_o  = ctrl_q.speed;
  assign an_restart_o = restart_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:TIMER_MSB+1], wdata_i[TIMER_LSB-1:10], wdata_i[8:5]};
endmodule

// File: rtl/eth_phy_csr_chk.sv
module eth_phy_csr_chk
  import eth_phy_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              an_done_i,
  input logic              an_restart_o
);
  logic known;
  assign known = (addr_i == ADDR_W'(A_CTRL))    || (addr_i == ADDR_W'(A_STATUS)) ||
                 (addr_i == ADDR_W'(A_PARTNER)) || (addr_i == ADDR_W'(A_TIMER))  ||
                 (addr_i == ADDR_W'(A_LPBK));

  a_r3_restart_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    an_restart_o |=> !an_restart_o);

  a_r3_restart_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(an_restart_o) |-> $past(wr_i && addr_i == ADDR_W'(A_CTRL) && wdata_i[CTRL_RESTART_BIT]));

  a_r4_done_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_STATUS)) |=> rdata_o[STAT_DONE_BIT] == $past(an_done_i));

  a_r6_partner_rsvd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_PARTNER)) |=> (rdata_o & ~{16'h0, PARTNER_MASK}) == '0);

  a_r7_timer_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(A_TIMER)) |=> rdata_o[TIMER_LSB-1:0] == '0);

  a_r9_undef_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !known) |=> rdata_o == '0);

  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind eth_phy_csr eth_phy_csr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_eth_phy_csr.sv
module sim_eth_phy_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        link = 1'b0, an_done = 1'b0;
  logic [15:0] partner = '0;
  logic        usx_mode, an_en, an_restart, lpbk;
  logic [2:0]  speed;
  logic [5:0]  timer;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  bit issued = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  eth_phy_csr u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .link_i(link), .an_done_i(an_done),
    .partner_ability_i(partner), .usx_mode_o(usx_mode), .an_en_o(an_en),
    .man_speed_o(speed), .an_restart_o(an_restart), .link_timer_o(timer),
    .serial_lpbk_o(lpbk)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: a read sampled at posedge yields rdata by the next negedge
  always @(posedge clk) begin
    issued <= rd && rst_n;
    if (an_restart) pulses++;
  end
  always @(negedge clk) begin
    if (issued) begin
      if (exp_q.size() == 0) check("R10 unexpected read", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_rd(input logic [10:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic do_wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    partner = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {21'b0, usx_mode, an_en, speed, an_restart, timer, lpbk},
          {21'b0, 1'b0, 1'b1, 3'b000, 1'b0, 6'h1F, 1'b0});
    do_rd(11'h400, 32'h0000_0002, "R1 ctrl reset");
    do_rd(11'h412, 32'h0007_C000, "R1 timer reset");
    do_rd(11'h461, 32'h0, "R1 lpbk reset");
    do_rd(11'h401, 32'h0, "R1 status reset");
    // R6 partner masking, two patterns
    do_rd(11'h405, 32'h0000_DF80, "R6 partner all ones");
    partner = 16'h5A35;
    do_rd(11'h405, 32'h0000_5A00 & 32'hDF80 | 32'h0, "R6 partner pattern");
    // R2 control fields, reserved bits ignored (R9)
    do_wr(11'h400, 32'hFFFF_FDFF);
    do_rd(11'h400, 32'h0000_001F, "R2 R9 ctrl all ones");
    check("R2 outputs ones", {29'b0, usx_mode, an_en, speed == 3'b111}, 32'h7);
    // R3 restart pulse
    pulses = 0;
    @(negedge clk);
    addr = 11'h400; wdata = 32'h0000_0209; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    check("R3 pulse high", {31'b0, an_restart}, 32'h1);
    @(negedge clk);
    check("R3 pulse cleared", {31'b0, an_restart}, 32'h0);
    check("R3 pulse count", pulses, 1);
    check("R2 outputs 1G", {27'b0, usx_mode, an_en, speed}, {27'b0, 1'b1, 1'b0, 3'b010});
    do_rd(11'h400, 32'h0000_0009, "R3 bit self-cleared");
    do_wr(11'h400, 32'h0000_0013);
    repeat (2) @(negedge clk);
    check("R3 no pulse on zero", pulses, 1);
    check("R2 speed 2.5G", {29'b0, speed}, 32'h4);
    // R7 timer field
    do_wr(11'h412, 32'hFFFF_FFFF);
    do_rd(11'h412, 32'h000F_C000, "R7 timer ones");
    check("R7 timer out", {26'b0, timer}, 32'h3F);
    do_wr(11'h412, 32'h0001_4000);
    do_rd(11'h412, 32'h0001_4000, "R7 timer 5");
    // R8 loopback
    do_wr(11'h461, 32'hFFFF_FFFF);
    do_rd(11'h461, 32'h1, "R8 lpbk set");
    check("R8 lpbk out", {31'b0, lpbk}, 32'h1);
    // R9 unmapped
    do_wr(11'h402, 32'hFFFF_FFFF);
    do_wr(11'h401, 32'hFFFF_FFFF);
    do_rd(11'h402, 32'h0, "R9 unmapped 402");
    do_rd(11'h7FF, 32'h0, "R9 unmapped 7FF");
    do_rd(11'h400, 32'h0000_0013, "R9 ctrl untouched");
    // R5 latched-low link, R4 done
    link = 1'b1;
    do_rd(11'h401, 32'h0, "R5 latched from reset");
    do_rd(11'h401, 32'h4, "R5 rearmed");
    @(negedge clk); link = 1'b0;
    @(negedge clk); link = 1'b1;
    repeat (2) @(negedge clk);
    do_rd(11'h401, 32'h0, "R5 drop held");
    an_done = 1'b1;
    do_rd(11'h401, 32'h24, "R4 R5 done and link");
    an_done = 1'b0;
    do_rd(11'h401, 32'h4, "R4 done low");
    // R10 hold
    repeat (3) @(negedge clk);
    check("R10 rdata held", rdata, 32'h4);
    repeat (2) @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule